// File: doc/BRIEF.md
# PLL Reference Select and Output Divider

This block is the digital clock-shaping logic that sits around an analog PLL core. It chooses the reference clock that the core locks to. That reference is either a trimmed internal 1 MHz clock or the crystal oscillator clock, and the oscillator clock passes through a programmable divider. The block also computes the multiply ratio that the core's feedback path needs. It divides the VCO output down to the PLL clock, and from that it derives the bus clock.

Until the core reports lock, the VCO output is divided by a fixed 4 and the programmed post-divide value is not used. Each divider takes a new ratio only when its current output period ends. Odd ratios keep a 50% duty cycle because a half-cycle delayed copy of the output is ANDed in. A ratio of 1 passes the input clock straight through. Source changes go through a glitch-free clock multiplexer, which synchronises its select into both clock domains.

Top module: `pll_refpost_div`

## Requirements
- R1: With `osc_en` low, `ref_clk` has the period of `irc_clk`.
- R2: With `osc_en` high, the period of `ref_clk` is (`ref_div` + 1) periods of `osc_clk`. `ref_div` is an unsigned 4-bit value, so the ratio runs from 1 to 16.
- R3: `vco_mult` equals 2 × (`syn_mul` + 1). `syn_mul` is an unsigned 6-bit value, so the output runs from 2 to 128.
- R4: While `pll_lock` is high, the period of `pll_clk` is (`post_div` + 1) periods of `vco_clk`. `post_div` is an unsigned 5-bit value, so the ratio runs from 1 to 32. A ratio of 1 passes `vco_clk` through.
- R5: While `pll_lock` is low, the period of `pll_clk` is 4 periods of `vco_clk`, whatever `post_div` holds. A divider cycle that ends without lock loads a ratio of 4.
- R6: With `pll_sel` high, `bus_clk` is `pll_clk` divided by 2. With `pll_sel` low, it is `ref_clk` divided by 2. The two bus sources are never enabled together.
- R7: The high time of every divided output is exactly half its period, for odd ratios as well as even ones.
- R8: A new ratio or a new lock state takes effect only when the current output period ends. No pulse on `pll_clk` is narrower than half a `vco_clk` period, and no pulse on `bus_clk` is narrower than one `vco_clk` period.
- R9: Switching the reference source never enables both sources together and never puts a pulse narrower than half an `osc_clk` period on `ref_clk`.
- R10: After reset, `ref_clk` follows `irc_clk` and `pll_clk` runs at `vco_clk`/4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| irc_clk | input | 1 | Trimmed internal 1 MHz clock |
| osc_clk | input | 1 | Oscillator clock |
| vco_clk | input | 1 | VCO output from the analog core |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | Selects the divided oscillator as the reference |
| ref_div | input | 4 | Reference divide value (ratio = value + 1) |
| syn_mul | input | 6 | Multiply field for the core |
| post_div | input | 5 | Post-divide value (ratio = value + 1) |
| pll_lock | input | 1 | Lock flag from the core's lock detector |
| pll_sel | input | 1 | Selects the PLL clock as the bus clock source |
| ref_clk | output | 1 | Reference clock to the core |
| pll_clk | output | 1 | Divided VCO clock |
| bus_clk | output | 1 | Bus clock, selected source divided by 2 |
| vco_mult | output | 8 | Multiply ratio for the core |

## Verification
The assertions run in the VCO domain and check four things on every cycle. The post-divider ratio changes only at a period boundary, its counter stays below its ratio, a boundary reached without lock loads the ratio 4, and neither clock multiplexer ever has both sources enabled. The bench scenarios cover what only edge timing can show. They measure the periods and high times for each divide setting, including the odd ratios and the divide-by-1 pass-through. They also track the narrowest pulse seen on each output while sources, ratios and lock state change under it.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;
  localparam int unsigned REF_DIV_W    = 4;
  localparam int unsigned MUL_W        = 6;
  localparam int unsigned POST_DIV_W   = 5;
  localparam int unsigned MULT_OUT_W   = MUL_W + 2;
  localparam int unsigned UNLOCK_RATIO = 4;
  localparam int unsigned SYNC_STAGES  = 2;
endpackage

// File: rtl/pll_bit_sync.sv
module pll_bit_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d[0] = d_i;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_comb chain_d[s] = chain_q[s-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pll_clk_divider.sv
// Integer clock divider. Ratio N = ratio_i (1..2^FIELD_W), captured at the
// end of each output period. Odd N: the output is the posedge phase ANDed
// with its half-cycle delayed copy, which gives an exact 50% duty cycle.
module pll_clk_divider #(
  parameter int unsigned FIELD_W   = 4,
  parameter int unsigned RST_RATIO = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [FIELD_W:0] ratio_i,
  output logic             clk_o
);
  localparam int unsigned RW = FIELD_W + 1;

  logic [FIELD_W-1:0] cnt_q, cnt_d;
  logic [RW-1:0]      ratio_q, ratio_d;
  logic [RW:0]        half_d;
  logic               hi_q, hi_d;
  logic               hi_n_q;
  logic               wrap;
  logic               bypass;
  logic               odd;

  always_comb begin
    wrap    = ({1'b0, cnt_q} + RW'(1)) >= ratio_q;
    cnt_d   = wrap ? '0 : cnt_q + FIELD_W'(1);
    ratio_d = wrap ? ratio_i : ratio_q;
    half_d  = ({1'b0, ratio_d} + (RW+1)'(1)) >> 1;
    hi_d    = ({2'b00, cnt_d} < half_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= RW'(RST_RATIO);
      hi_q    <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      hi_q    <= hi_d;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_n_q <= 1'b0;
    else         hi_n_q <= hi_q;
  end

  always_comb begin
    bypass = (ratio_q == RW'(1));
    odd    = ratio_q[0];
    if (bypass)   clk_o = clk_i;
    else if (odd) clk_o = hi_q & hi_n_q;
    else          clk_o = hi_q;
  end
endmodule

// File: rtl/pll_clk_gf_mux.sv
// Glitch-free two-input clock mux. Each side owns a two-stage enable
// synchroniser on its falling edge and waits for the other side to drop.
module pll_clk_gf_mux (
  input  logic clk_a_i,
  input  logic rst_a_ni,
  input  logic clk_b_i,
  input  logic rst_b_ni,
  input  logic sel_b_i,
  output logic clk_o
);
  logic ena_s, ena_q, ena_d;
  logic enb_s, enb_q, enb_d;

  always_comb begin
    ena_d = ~sel_b_i & ~enb_q;
    enb_d =  sel_b_i & ~ena_q;
  end

  always_ff @(negedge clk_a_i or negedge rst_a_ni) begin
    if (!rst_a_ni) begin
      ena_s <= 1'b1;
      ena_q <= 1'b1;
    end else begin
      ena_s <= ena_d;
      ena_q <= ena_s;
    end
  end

  always_ff @(negedge clk_b_i or negedge rst_b_ni) begin
    if (!rst_b_ni) begin
      enb_s <= 1'b0;
      enb_q <= 1'b0;
    end else begin
      enb_s <= enb_d;
      enb_q <= enb_s;
    end
  end

  assign clk_o = (clk_a_i & ena_q) | (clk_b_i & enb_q);
endmodule

// File: rtl/pll_refpost_div.sv
module pll_refpost_div
  import pll_div_pkg::*;
#(
  parameter int unsigned RDIV_W  = REF_DIV_W,
  parameter int unsigned SMUL_W  = MUL_W,
  parameter int unsigned PDIV_W  = POST_DIV_W,
  parameter int unsigned UNLK_N  = UNLOCK_RATIO,
  parameter int unsigned SYNC_N  = SYNC_STAGES,
  localparam int unsigned MOUT_W = SMUL_W + 2
) (
  input  logic              irc_clk,
  input  logic              osc_clk,
  input  logic              vco_clk,
  input  logic              rst_n,
  input  logic              osc_en,
  input  logic [RDIV_W-1:0] ref_div,
  input  logic [SMUL_W-1:0] syn_mul,
  input  logic [PDIV_W-1:0] post_div,
  input  logic              pll_lock,
  input  logic              pll_sel,
  output logic              ref_clk,
  output logic              pll_clk,
  output logic              bus_clk,
  output logic [MOUT_W-1:0] vco_mult
);
  localparam int unsigned RR_W = RDIV_W + 1;
  localparam int unsigned PR_W = PDIV_W + 1;

  logic irc_rst_n, osc_rst_n, vco_rst_n, bus_rst_n;
  logic osc_div_clk;
  logic bus_src_clk;
  logic lock_s;
  logic [RR_W-1:0] ref_ratio;
  logic [PR_W-1:0] post_ratio;

  // Per-domain reset release
  pll_bit_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_irc_rst (
    .clk_i(irc_clk), .rst_ni(rst_n), .d_i(1'b1), .q_o(irc_rst_n));
  pll_bit_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_osc_rst (
    .clk_i(osc_clk), .rst_ni(rst_n), .d_i(1'b1), .q_o(osc_rst_n));
  pll_bit_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_vco_rst (
    .clk_i(vco_clk), .rst_ni(rst_n), .d_i(1'b1), .q_o(vco_rst_n));
  pll_bit_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_bus_rst (
    .clk_i(bus_src_clk), .rst_ni(rst_n), .d_i(1'b1), .q_o(bus_rst_n));

  // Reference path
  always_comb ref_ratio = RR_W'(ref_div) + RR_W'(1);

  pll_clk_divider #(.FIELD_W(RDIV_W), .RST_RATIO(1)) u_ref_div (
    .clk_i(osc_clk), .rst_ni(osc_rst_n), .ratio_i(ref_ratio), .clk_o(osc_div_clk));

  pll_clk_gf_mux u_ref_mux (
    .clk_a_i(irc_clk), .rst_a_ni(irc_rst_n),
    .clk_b_i(osc_div_clk), .rst_b_ni(osc_rst_n),
    .sel_b_i(osc_en), .clk_o(ref_clk));

  // Multiply ratio for the analog feedback divider
  always_comb vco_mult = MOUT_W'({syn_mul, 1'b0}) + MOUT_W'(2);

  // Post-divider with unlocked fallback
  pll_bit_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_lock_sync (
    .clk_i(vco_clk), .rst_ni(vco_rst_n), .d_i(pll_lock), .q_o(lock_s));

  always_comb post_ratio = lock_s ? (PR_W'(post_div) + PR_W'(1)) : PR_W'(UNLK_N);

  pll_clk_divider #(.FIELD_W(PDIV_W), .RST_RATIO(UNLK_N)) u_post_div (
    .clk_i(vco_clk), .rst_ni(vco_rst_n), .ratio_i(post_ratio), .clk_o(pll_clk));

  // Bus clock
  pll_clk_gf_mux u_bus_mux (
    .clk_a_i(ref_clk), .rst_a_ni(irc_rst_n),
    .clk_b_i(pll_clk), .rst_b_ni(vco_rst_n),
    .sel_b_i(pll_sel), .clk_o(bus_src_clk));

  pll_clk_divider #(.FIELD_W(1), .RST_RATIO(2)) u_bus_div (
    .clk_i(bus_src_clk), .rst_ni(bus_rst_n), .ratio_i(2'd2), .clk_o(bus_clk));
endmodule

// File: rtl/pll_refpost_div_chk.sv
module pll_refpost_div_chk (
  input logic       vco_clk,
  input logic       rst_n,
  input logic       lock_s,
  input logic       post_wrap,
  input logic [4:0] post_cnt,
  input logic [5:0] post_ratio,
  input logic       ref_ena,
  input logic       ref_enb,
  input logic       bus_ena,
  input logic       bus_enb
);
  assert_ratio_hold_R8: assert property (@(posedge vco_clk) disable iff (!rst_n)
    !$stable(post_ratio) |-> $past(post_wrap));

  assert_cnt_bound_R8: assert property (@(posedge vco_clk) disable iff (!rst_n)
    {1'b0, post_cnt} < post_ratio);

  assert_unlock_ratio_R5: assert property (@(posedge vco_clk) disable iff (!rst_n)
    (post_wrap && !lock_s) |=> (post_ratio == 6'd4));

  assert_ref_excl_R9: assert property (@(posedge vco_clk) disable iff (!rst_n)
    $onehot0({ref_ena, ref_enb}));

  assert_bus_excl_R6: assert property (@(posedge vco_clk) disable iff (!rst_n)
    $onehot0({bus_ena, bus_enb}));
endmodule

bind pll_refpost_div pll_refpost_div_chk u_chk (
  .vco_clk   (vco_clk),
  .rst_n     (vco_rst_n),
  .lock_s    (lock_s),
  .post_wrap (u_post_div.wrap),
  .post_cnt  (u_post_div.cnt_q),
  .post_ratio(u_post_div.ratio_q),
  .ref_ena   (u_ref_mux.ena_q),
  .ref_enb   (u_ref_mux.enb_q),
  .bus_ena   (u_bus_mux.ena_q),
  .bus_enb   (u_bus_mux.enb_q)
);

// File: tb/pll_refpost_div_tb_top.sv
module pll_refpost_div_tb_top;
  localparam int CLK_PERIOD = 10;   // vco_clk
  localparam int OSC_PERIOD = 30;
  localparam int IRC_PERIOD = 100;
  localparam int WATCHDOG   = 1500000;

  logic irc_clk, osc_clk, vco_clk, rst_n;
  logic osc_en, pll_lock, pll_sel;
  logic [3:0] ref_div;
  logic [5:0] syn_mul;
  logic [4:0] post_div;
  logic ref_clk, pll_clk, bus_clk;
  logic [7:0] vco_mult;

  int n_checks = 0;
  int n_fails  = 0;
  int psel     = 0;
  bit mon_on   = 1'b0;
  bit done     = 1'b0;

  pll_refpost_div dut_i (
    .irc_clk(irc_clk), .osc_clk(osc_clk), .vco_clk(vco_clk), .rst_n(rst_n),
    .osc_en(osc_en), .ref_div(ref_div), .syn_mul(syn_mul), .post_div(post_div),
    .pll_lock(pll_lock), .pll_sel(pll_sel),
    .ref_clk(ref_clk), .pll_clk(pll_clk), .bus_clk(bus_clk), .vco_mult(vco_mult));

  initial begin vco_clk = 1'b0; forever #(CLK_PERIOD/2) vco_clk = ~vco_clk; end
  initial begin osc_clk = 1'b0; forever #(OSC_PERIOD/2) osc_clk = ~osc_clk; end
  initial begin irc_clk = 1'b0; forever #(IRC_PERIOD/2) irc_clk = ~irc_clk; end

  wire probe = (psel == 0) ? ref_clk : (psel == 1) ? pll_clk : bus_clk;

  // Narrowest pulse monitors
  real pll_last = 0.0, ref_last = 0.0, bus_last = 0.0;
  real pll_min = 1.0e9, ref_min = 1.0e9, bus_min = 1.0e9;
  always @(pll_clk) if (mon_on) begin
    if ($realtime - pll_last < pll_min) pll_min = $realtime - pll_last;
    pll_last = $realtime;
  end
  always @(ref_clk) if (mon_on) begin
    if ($realtime - ref_last < ref_min) ref_min = $realtime - ref_last;
    ref_last = $realtime;
  end
  always @(bus_clk) if (mon_on) begin
    if ($realtime - bus_last < bus_min) bus_min = $realtime - bus_last;
    bus_last = $realtime;
  end

  task automatic check_real(input real act, input real exp, input string what);
    n_checks++;
    if ((act - exp > 0.01) || (exp - act > 0.01)) begin
      n_fails++;
      $display("FAIL %s actual=%0.2f expected=%0.2f", what, act, exp);
    end
  endtask

  task automatic check_int(input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic check_min(input real act, input real lim, input string what);
    n_checks++;
    if (act < lim) begin
      n_fails++;
      $display("FAIL %s actual=%0.2f expected>=%0.2f", what, act, lim);
    end
  endtask

  task automatic measure(input int sel, input real exp_t, input string what);
    real t0, t1, t2;
    psel = sel;
    repeat (6) @(posedge probe);
    @(posedge probe); t0 = $realtime;
    @(negedge probe); t1 = $realtime;
    @(posedge probe); t2 = $realtime;
    check_real(t2 - t0, exp_t, {what, " period"});
    check_real(t1 - t0, exp_t / 2.0, {what, " high time (R7)"});
  endtask

  task automatic t_reset;
    rst_n = 1'b0; osc_en = 1'b0; pll_lock = 1'b0; pll_sel = 1'b0;
    ref_div = 4'd0; syn_mul = 6'd0; post_div = 5'd9;
    #(3*IRC_PERIOD);
    rst_n = 1'b1;
    measure(0, IRC_PERIOD, "R10 ref after reset");
    measure(1, 4*CLK_PERIOD, "R10 pll after reset");
    measure(2, 2*IRC_PERIOD, "R6 bus from ref");
    mon_on = 1'b1;
  endtask

  task automatic t_mult;
    syn_mul = 6'd0;  #1; check_int(int'(vco_mult), 2,   "R3 mult min");
    syn_mul = 6'd63; #1; check_int(int'(vco_mult), 128, "R3 mult max");
    syn_mul = 6'd20; #1; check_int(int'(vco_mult), 42,  "R3 mult mid");
  endtask

  task automatic t_osc_ref;
    osc_en = 1'b1;
    ref_div = 4'd0;  measure(0, OSC_PERIOD,      "R2 ref div1");
    ref_div = 4'd4;  measure(0, 5*OSC_PERIOD,    "R2 ref div5");
    ref_div = 4'd2;  measure(0, 3*OSC_PERIOD,    "R2 ref div3");
    ref_div = 4'd15; measure(0, 16*OSC_PERIOD,   "R2 ref div16");
  endtask

  task automatic t_back_irc;
    osc_en = 1'b0;
    measure(0, IRC_PERIOD, "R1 ref back to irc");
  endtask

  task automatic t_locked;
    pll_lock = 1'b1;
    post_div = 5'd0;  measure(1, CLK_PERIOD,    "R4 pll bypass");
    post_div = 5'd2;  measure(1, 3*CLK_PERIOD,  "R4 pll div3");
    post_div = 5'd31; measure(1, 32*CLK_PERIOD, "R4 pll div32");
    post_div = 5'd6;  measure(1, 7*CLK_PERIOD,  "R4 pll div7");
  endtask

  task automatic t_unlock;
    pll_lock = 1'b0;
    measure(1, 4*CLK_PERIOD, "R5 pll unlocked ignores post_div");
    post_div = 5'd0;
    measure(1, 4*CLK_PERIOD, "R5 pll unlocked bypass field");
  endtask

  task automatic t_bus;
    pll_lock = 1'b1; post_div = 5'd2; pll_sel = 1'b1;
    measure(2, 6*CLK_PERIOD, "R6 bus from pll");
    pll_sel = 1'b0;
    measure(2, 2*IRC_PERIOD, "R6 bus back to ref");
  endtask

  task automatic t_pulses;
    check_min(pll_min, CLK_PERIOD/2.0, "R8 narrowest pll pulse");
    check_min(bus_min, CLK_PERIOD,     "R8 narrowest bus pulse");
    check_min(ref_min, OSC_PERIOD/2.0, "R9 narrowest ref pulse");
  endtask

  initial begin
    #(WATCHDOG);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog R1..: actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_mult();
    t_osc_ref();
    t_back_irc();
    t_locked();
    t_unlock();
    t_bus();
    t_pulses();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule